// File: doc/BRIEF.md
# Serial-Loaded Shift-Add Multiplier

This block multiplies two unsigned N-bit numbers (default N = 3) using one narrow adder over several clock steps. The multiplicand is presented in parallel. The multiplier is fed in one bit per step through a serial input, most significant bit first. There is no start or load strobe. Every state change is qualified by a single-cycle `shift_en` pulse. The block counts its own steps and moves through four phases: load, multiply, done and flush.

In the **IDLE_LOAD** state, each enabled step shifts `ser_in` into the multiplier register from the bottom. After N steps the transition *load_full* moves the block to **ADD_SHIFT**. In that state, each enabled step does three things:

- ANDs the multiplicand with the lowest multiplier bit.
- Adds the result into the accumulator, keeping the carry.
- Shifts {carry, accumulator, multiplier} one place right.

After N such steps, the transition *mult_over* enters **READY**, where `done` is high and the 2N-bit product is held. The first enabled step in READY (transition *drain_start*) begins **DRAIN**. There, zeros are shifted in from the top until 2N shifts in total have emptied every register. The transition *drain_over* then returns the block to IDLE_LOAD. A synchronous reset forces IDLE_LOAD with all registers at zero.

Top module: `serial_shift_mult`

## Requirements
- R1: While `rst` is high at a clock edge, the block is reset: after that edge `product` is 0 and `done` is 0, and the next enabled step is the first load step.
- R2: In the load phase, each enabled step shifts `ser_in` into bit 0 of the multiplier register and moves its older bits up. The multiplier is entered MSB first. After N load steps, `product[N-1:0]` equals the multiplier, `product[2N-1:N]` is 0, and `done` is 0.
- R3: After N further enabled steps following the load, `product` equals `mcand` × multiplier as an unsigned 2N-bit value. Each step adds `mcand` AND the current low multiplier bit, with carry, and then shifts right by one. No operand pair overflows.
- R4: `done` is 1 exactly from the edge of the 2N-th enabled step after reset or after a completed drain, until the next enabled step. At all other times `done` is 0.
- R5: While `shift_en` is low, `product` and `done` keep their values.
- R6: `ser_in` has no effect outside the load phase, and `mcand` has no effect outside the multiply phase.
- R7: From the done state, each enabled step shifts `product` right by one with a zero fill. After 2N such steps, `product` is 0, `done` is 0, and the block accepts a new multiplier load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Single-cycle step qualifier |
| ser_in | input | 1 | Serial multiplier bit, MSB first |
| mcand | input | N | Parallel multiplicand |
| product | output | 2N | {accumulator, multiplier register} |
| done | output | 1 | High while the finished product is held |

## Verification
The assertions rely on `shift_en` being the only thing that advances the block. They also rely on every step sequence since reset being counted whole: load, multiply, done and drain, 4N enabled steps per cycle. The stimulus therefore never abandons an operation except by asserting `rst`. The stimulus also keeps `mcand` steady throughout the multiply phase. It changes `ser_in` and `mcand` freely only in the phases where R6 says they are ignored, and it inserts idle cycles with `shift_en` low between steps.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_MULT  = 2'd1,
        ST_READY = 2'd2,
        ST_DRAIN = 2'd3
    } smul_state_t;

    typedef enum logic [1:0] {
        DP_HOLD  = 2'd0,
        DP_LOAD  = 2'd1,
        DP_ADDSH = 2'd2,
        DP_SHR   = 2'd3
    } smul_op_t;

endpackage

// File: rtl/smul_and_row.sv
module smul_and_row #(
    parameter int N = 3
) (
    input  logic [N-1:0] mcand,
    input  logic         sel,
    output logic [N-1:0] pp
);

    for (genvar i = 0; i < N; i++) begin : g_and
        assign pp[i] = mcand[i] & sel;
    end

endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
    import smul_pkg::*;
#(
    parameter int N = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     shift_en,
    output smul_op_t op,
    output logic     done
);

    localparam int CW = $clog2(2 * N);
    localparam logic [CW-1:0] LAST_HALF = CW'(N - 1);
    localparam logic [CW-1:0] LAST_FULL = CW'(2 * N - 1);

    smul_state_t     state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // next state and step count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (shift_en) begin
            unique case (state_q)
                ST_LOAD: begin
                    if (cnt_q == LAST_HALF) begin
                        state_d = ST_MULT;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_MULT: begin
                    if (cnt_q == LAST_HALF) begin
                        state_d = ST_READY;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_READY: begin
                    state_d = ST_DRAIN;
                    cnt_d   = CW'(1);
                end
                ST_DRAIN: begin
                    if (cnt_q == LAST_FULL) begin
                        state_d = ST_LOAD;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        op   = DP_HOLD;
        done = (state_q == ST_READY);
        if (shift_en) begin
            unique case (state_q)
                ST_LOAD:  op = DP_LOAD;
                ST_MULT:  op = DP_ADDSH;
                ST_READY: op = DP_SHR;
                ST_DRAIN: op = DP_SHR;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOAD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/smul_datapath.sv
module smul_datapath
    import smul_pkg::*;
#(
    parameter int N = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  smul_op_t       op,
    input  logic           ser_in,
    input  logic [N-1:0]   mcand,
    output logic [2*N-1:0] product
);

    logic [N-1:0] acc_q;
    logic [N-1:0] mreg_q;
    logic [N-1:0] pp;
    logic [N:0]   sum;

    smul_and_row #(.N(N)) u_row (
        .mcand (mcand),
        .sel   (mreg_q[0]),
        .pp    (pp)
    );

    assign sum     = {1'b0, acc_q} + {1'b0, pp};
    assign product = {acc_q, mreg_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            mreg_q <= '0;
        end else begin
            unique case (op)
                DP_HOLD: ;
                DP_LOAD: begin
                    mreg_q <= (mreg_q << 1) | N'(ser_in);
                end
                DP_ADDSH: begin
                    acc_q  <= sum[N:1];
                    mreg_q <= {sum[0], mreg_q[N-1:1]};
                end
                DP_SHR: begin
                    acc_q  <= acc_q >> 1;
                    mreg_q <= {acc_q[0], mreg_q[N-1:1]};
                end
            endcase
        end
    end

endmodule

// File: rtl/serial_shift_mult.sv
module serial_shift_mult
    import smul_pkg::*;
#(
    parameter int N = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           ser_in,
    input  logic [N-1:0]   mcand,
    output logic [2*N-1:0] product,
    output logic           done
);

    smul_op_t op;

    smul_ctrl #(.N(N)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .op       (op),
        .done     (done)
    );

    smul_datapath #(.N(N)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .ser_in  (ser_in),
        .mcand   (mcand),
        .product (product)
    );

endmodule

// File: rtl/smul_checker.sv
module smul_checker #(
    parameter int N = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           shift_en,
    input logic [2*N-1:0] product,
    input logic           done
);

    localparam int PW = $clog2(4 * N);
    localparam logic [PW-1:0] PH_LAST  = PW'(4 * N - 1);
    localparam logic [PW-1:0] PH_READY = PW'(2 * N);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else if (shift_en)
            phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (product == '0) && !done);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(product) && $stable(done));

    // R4
    done_timing_chk: assert property (@(posedge clk) disable iff (rst)
        done == (phase == PH_READY));

    // R4
    done_release_chk: assert property (@(posedge clk) disable iff (rst)
        done && shift_en |=> !done);

    // R7
    drain_shift_chk: assert property (@(posedge clk) disable iff (rst)
        done && shift_en |=> product == ($past(product) >> 1));

endmodule

bind serial_shift_mult smul_checker #(.N(N)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .product  (product),
    .done     (done)
);

// File: tb/sim_serial_shift_mult.sv
module sim_serial_shift_mult;

    localparam int N = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           shift_en = 1'b0;
    logic           ser_in = 1'b0;
    logic [N-1:0]   mcand = '0;
    logic [2*N-1:0] product;
    logic           done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    serial_shift_mult #(.N(N)) u0 (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .ser_in   (ser_in),
        .mcand    (mcand),
        .product  (product),
        .done     (done)
    );

    function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        return (2*N)'(a) * (2*N)'(b);
    endfunction

    task automatic chk(input string tag, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic en, input logic sin);
        @(negedge clk);
        shift_en = en;
        ser_in   = sin;
        @(posedge clk);
        #1;
        shift_en = 1'b0;
    endtask

    task automatic run_mult(input logic [N-1:0] a, input logic [N-1:0] b,
                            input bit gaps, input bit junk);
        logic [2*N-1:0] expv;
        logic [2*N-1:0] held;
        // load phase, MSB first (R2); mcand ignored here (R6)
        for (int i = 0; i < N; i++) begin
            if (junk) mcand = N'($urandom);
            step(1'b1, b[N-1-i]);
            if (gaps) step(1'b0, 1'($urandom));
        end
        chk("R2 loaded multiplier", product, (2*N)'(b));
        chk("R2 done low after load", (2*N)'(done), '0);
        // multiply phase; ser_in ignored (R6)
        mcand = a;
        for (int i = 0; i < N; i++) begin
            step(1'b1, junk ? 1'($urandom) : 1'b0);
            if (gaps) step(1'b0, 1'($urandom));
        end
        chk(junk ? "R3 R6 product" : "R3 product", product, ref_mul(a, b));
        chk("R4 done high", (2*N)'(done), (2*N)'(1));
        // hold while idle (R5)
        held = product;
        if (junk) mcand = N'($urandom);
        step(1'b0, 1'($urandom));
        step(1'b0, 1'($urandom));
        chk("R5 product held", product, held);
        chk("R5 done held", (2*N)'(done), (2*N)'(1));
        // drain (R7)
        expv = held;
        for (int i = 0; i < 2*N; i++) begin
            if (junk) mcand = N'($urandom);
            step(1'b1, junk ? 1'($urandom) : 1'b0);
            expv = expv >> 1;
            chk("R7 drain shift", product, expv);
            if (i == 0) chk("R4 done released", (2*N)'(done), '0);
            if (gaps) step(1'b0, 1'($urandom));
        end
        chk("R7 cleared product", product, '0);
        chk("R7 cleared done", (2*N)'(done), '0);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd1357);
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        // R1
        chk("R1 reset product", product, '0);
        chk("R1 reset done", (2*N)'(done), '0);

        // directed: 6 x 7 and corners
        run_mult(3'd6, 3'd7, 1'b0, 1'b0);
        run_mult(3'd7, 3'd7, 1'b1, 1'b0);
        run_mult(3'd0, 3'd7, 1'b0, 1'b1);
        run_mult(3'd5, 3'd0, 1'b1, 1'b1);

        // reset in the middle of a load (R1)
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid-load reset product", product, '0);
        chk("R1 mid-load reset done", (2*N)'(done), '0);
        run_mult(3'd3, 3'd5, 1'b0, 1'b0);

        // exhaustive pairs
        for (int a = 0; a < (1 << N); a++)
            for (int b = 0; b < (1 << N); b++)
                run_mult(N'(a), N'(b), 1'($urandom), 1'($urandom));

        // random mix
        for (int t = 0; t < 100; t++)
            run_mult(N'($urandom), N'($urandom), 1'($urandom), 1'($urandom));

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule